// File: doc/BRIEF.md
# Presence-Detect Byte Store with Block Write Locks

This block holds the 512-byte content of a memory-module identification store. A host reaches it through a plain register-style port. Each cycle the host presents an address, and it may also assert a write strobe with a data byte. The byte at that address appears on the read port in the following cycle. The address space is split into four 128-byte blocks. The upper two address bits select the block.

The lower three blocks can be locked against writes, and each lock can later be released again. Software controls the locks through one 4-bit lock register. It has a set strobe and a clear strobe, and both use a shared bit mask. The top block holds user data. Its lock bit does not exist and reads as zero. A 64-byte window inside block 2 is reserved: it always reads as zero and never stores anything. A write that hits a locked block is dropped, and the block raises a one-cycle rejection pulse.

The serial bus front end and nonvolatile retention are outside this block. The storage here is a register array, cleared at reset.

Top module: `spd_store`

## Requirements
- R1: After reset, `prot_state` is 0000, `rdata` is 00h, `wr_reject` is 0, and every byte of the array reads as 00h.
- R2: `rdata` shows the byte at the `addr` given in the previous cycle. A write and a read of the same address in one cycle return the old byte.
- R3: A write with `wr_en`=1 to an unlocked, non-reserved address stores `wdata`. A later read of that address returns it.
- R4: A write to a byte whose block lock bit is 1 leaves that byte unchanged.
- R5: `wr_reject` is 1 in exactly the cycle after a write that was dropped because its block was locked, and 0 in every other cycle.
- R6: `prot_set` ORs `prot_mask` into the lock register and `prot_clr` clears the masked bits. When both strobes are high, clear wins for every masked bit. A released block accepts writes again.
- R7: Lock bit 3 always reads 0. Addresses 384 to 511 accept writes under any lock state and never raise `wr_reject`.
- R8: Addresses 256 to 319 always read 00h. A write there is discarded. It raises `wr_reject` only when block 2 is locked.
- R9: A write and a lock-register update in the same cycle are judged against the lock state from before that edge.
- R10: Block number is `addr[8:7]`. Block 0 spans 000h–07Fh, block 1 spans 080h–0FFh, block 2 spans 100h–17Fh and block 3 spans 180h–1FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 9 | Byte address for the read and the write |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe |
| prot_set | input | 1 | Set the lock bits selected by `prot_mask` |
| prot_clr | input | 1 | Clear the lock bits selected by `prot_mask` |
| prot_mask | input | 4 | Lock bit mask, bit n for block n |
| rdata | output | 8 | Read byte, registered |
| wr_reject | output | 1 | One-cycle pulse after a locked write was dropped |
| prot_state | output | 4 | Current lock register |

## Verification
A byte write and a lock-register update can land on the same edge. The same holds for a set strobe and a clear strobe. The bench issues a write to a block in the very cycle that the block's lock is set, and again in the cycle that it is released. It also raises both strobes together on overlapping masks. The stored byte is judged by a later read, the rejection pulse in the next cycle, and the lock register against the clear-wins rule. The random phase produces these collisions at random, and a reference model in the bench judges each one.

// File: rtl/spd_pkg.sv
package spd_pkg;

   typedef enum logic [1:0] {
      WR_IDLE     = 2'd0,
      WR_ACCEPT   = 2'd1,
      WR_DROP_RSV = 2'd2,
      WR_DROP_LCK = 2'd3
   } wr_verdict_e;

   function automatic logic in_window(input int unsigned a,
                                      input int unsigned lo,
                                      input int unsigned hi);
      return (a >= lo) && (a < hi);
   endfunction

   function automatic int unsigned low_ones(input int unsigned n);
      int unsigned m;
      m = 0;
      for (int unsigned i = 0; i < 32; i++)
         if (i < n) m = m | (32'd1 << i);
      return m;
   endfunction

endpackage

// File: rtl/spd_lock_reg.sv
module spd_lock_reg #(
   parameter int unsigned NUM_BLK   = 4,
   parameter int unsigned PROT_BLKS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_stb,
   input  logic               clr_stb,
   input  logic [NUM_BLK-1:0] mask,
   output logic [NUM_BLK-1:0] state
);
   localparam logic [NUM_BLK-1:0] IMPL = NUM_BLK'(spd_pkg::low_ones(PROT_BLKS));

   if (PROT_BLKS > NUM_BLK) begin : g_bad_cnt
      $error("spd_lock_reg: PROT_BLKS exceeds NUM_BLK");
   end

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_bit
      if (b < PROT_BLKS) begin : g_flop
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    q <= 1'b0;
            else if (clr_stb && mask[b])   q <= 1'b0;
            else if (set_stb && mask[b])   q <= 1'b1;
         end
         assign state[b] = q;
      end else begin : g_tie
         assign state[b] = 1'b0;
      end
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && !clr_stb) |=> ((state & $past(mask & IMPL)) == $past(mask & IMPL))); // R6
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((state & $past(mask)) == '0)); // R6
   AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(state)); // R6

endmodule

// File: rtl/spd_wr_gate.sv
module spd_wr_gate #(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned BLK_W   = 7,
   parameter int unsigned NUM_BLK = 4,
   parameter int unsigned RSV_LO  = 256,
   parameter int unsigned RSV_HI  = 320
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr_en,
   input  logic [NUM_BLK-1:0]  lock,
   output spd_pkg::wr_verdict_e verdict,
   output logic                store_en
);
   localparam int unsigned SEL_W = ADDR_W - BLK_W;

   logic [SEL_W-1:0] blk;
   logic             rsv_hit;
   logic             locked;

   assign blk     = addr[ADDR_W-1:BLK_W];
   assign rsv_hit = spd_pkg::in_window(32'(addr), RSV_LO, RSV_HI);
   assign locked  = lock[blk];

   always_comb begin
      if (!wr_en)       verdict = spd_pkg::WR_IDLE;
      else if (locked)  verdict = spd_pkg::WR_DROP_LCK;
      else if (rsv_hit) verdict = spd_pkg::WR_DROP_RSV;
      else              verdict = spd_pkg::WR_ACCEPT;
   end

   assign store_en = (verdict == spd_pkg::WR_ACCEPT);

endmodule

// File: rtl/spd_byte_array.sv
module spd_byte_array #(
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned RSV_LO      = 256,
   parameter int unsigned RSV_HI      = 320,
   parameter bit          RESET_ARRAY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic              rsv_rd;

   assign rsv_rd = spd_pkg::in_window(32'(raddr), RSV_LO, RSV_HI);

   if (RESET_ARRAY) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[waddr] <= wdata;
         end
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (rsv_rd) rdata <= '0;
      else             rdata <= mem[raddr];
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata))); // R3

endmodule

// File: rtl/spd_store.sv
module spd_store #(
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BLK_W       = 7,
   parameter int unsigned PROT_BLKS   = 3,
   parameter int unsigned RSV_LO      = 256,
   parameter int unsigned RSV_HI      = 320,
   parameter bit          RESET_ARRAY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [8:0]        addr,
   input  logic [7:0]        wdata,
   input  logic              wr_en,
   input  logic              prot_set,
   input  logic              prot_clr,
   input  logic [3:0]        prot_mask,
   output logic [7:0]        rdata,
   output logic              wr_reject,
   output logic [3:0]        prot_state
);
   localparam int unsigned SEL_W   = ADDR_W - BLK_W;
   localparam int unsigned NUM_BLK = 1 << SEL_W;
   localparam int unsigned DEPTH   = 1 << ADDR_W;

   if (ADDR_W != 9 || DATA_W != 8 || NUM_BLK != 4) begin : g_bad_shape
      $error("spd_store: port widths fix ADDR_W=9, DATA_W=8, four blocks");
   end
   if (BLK_W >= ADDR_W) begin : g_bad_blk
      $error("spd_store: BLK_W must be below ADDR_W");
   end
   if (PROT_BLKS > NUM_BLK) begin : g_bad_prot
      $error("spd_store: PROT_BLKS exceeds block count");
   end
   if (RSV_LO > RSV_HI || RSV_HI > DEPTH) begin : g_bad_rsv
      $error("spd_store: reserved window out of range");
   end

   spd_pkg::wr_verdict_e verdict;
   logic                 store_en;

   spd_lock_reg #(
      .NUM_BLK   (NUM_BLK),
      .PROT_BLKS (PROT_BLKS)
   ) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (prot_set),
      .clr_stb (prot_clr),
      .mask    (prot_mask),
      .state   (prot_state)
   );

   spd_wr_gate #(
      .ADDR_W  (ADDR_W),
      .BLK_W   (BLK_W),
      .NUM_BLK (NUM_BLK),
      .RSV_LO  (RSV_LO),
      .RSV_HI  (RSV_HI)
   ) u_gate (
      .addr     (addr),
      .wr_en    (wr_en),
      .lock     (prot_state),
      .verdict  (verdict),
      .store_en (store_en)
   );

   spd_byte_array #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .RSV_LO      (RSV_LO),
      .RSV_HI      (RSV_HI),
      .RESET_ARRAY (RESET_ARRAY)
   ) u_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (store_en),
      .waddr (addr),
      .wdata (wdata),
      .raddr (addr),
      .rdata (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_reject <= 1'b0;
      else        wr_reject <= (verdict == spd_pkg::WR_DROP_LCK);
   end

   logic rsv_addr;
   assign rsv_addr = spd_pkg::in_window(32'(addr), RSV_LO, RSV_HI);

   AST_REJECT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> $past(wr_en)); // R5
   AST_LOCK_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && prot_state[addr[ADDR_W-1:BLK_W]]) |-> !store_en); // R4
   AST_USER_BLOCK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> (32'($past(addr[ADDR_W-1:BLK_W])) < PROT_BLKS)); // R7
   AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rsv_addr) |-> (rdata == '0)); // R8
   AST_RSV_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_addr |-> !store_en); // R8

endmodule

// File: tb/sim_spd_store.sv
module sim_spd_store;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr_en = 1'b0;
   logic       prot_set = 1'b0;
   logic       prot_clr = 1'b0;
   logic [3:0] prot_mask = '0;
   logic [7:0] rdata;
   logic       wr_reject;
   logic [3:0] prot_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [7:0] exp_mem [512];
   logic [3:0] exp_lock;

   always #(CLK_PERIOD/2) clk = ~clk;

   spd_store u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .prot_set(prot_set), .prot_clr(prot_clr), .prot_mask(prot_mask),
      .rdata(rdata), .wr_reject(wr_reject), .prot_state(prot_state));

   function automatic bit is_rsv(input logic [8:0] a);
      return (a >= 9'd256) && (a < 9'd320);
   endfunction

   function automatic bit is_locked(input logic [8:0] a, input logic [3:0] lk);
      return lk[a[8:7]];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, sample at next negedge
   task automatic op(input logic [8:0] a, input logic [7:0] d, input bit we,
                     input bit st, input bit cl, input logic [3:0] m, input string tag);
      logic [7:0] e_rd;
      bit         e_rej;
      logic [3:0] nl;
      addr = a; wdata = d; wr_en = we;
      prot_set = st; prot_clr = cl; prot_mask = m;
      e_rd  = is_rsv(a) ? 8'h00 : exp_mem[a];
      e_rej = we && is_locked(a, exp_lock);
      if (we && !e_rej && !is_rsv(a)) exp_mem[a] = d;
      nl = exp_lock;
      if (st) nl = nl | m;
      if (cl) nl = nl & ~m;
      exp_lock = nl & 4'b0111;
      @(posedge clk);
      @(negedge clk);
      chk(rdata == e_rd, tag, rdata, e_rd);
      chk(wr_reject == e_rej, "R5", wr_reject, e_rej);
      chk(prot_state == exp_lock, "R6", prot_state, exp_lock);
      wr_en = 1'b0; prot_set = 1'b0; prot_clr = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, input string tag);
      op(a, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);
      for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
      exp_lock = 4'h0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(prot_state == 4'h0, "R1", prot_state, 0);
      chk(rdata == 8'h00, "R1", rdata, 0);
      chk(wr_reject == 1'b0, "R1", wr_reject, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(9'd5, "R1");
      rd(9'd450, "R1");

      // R3/R10: a write into each block, read back
      op(9'h000, 8'hA1, 1, 0, 0, 4'h0, "R3");
      op(9'h07F, 8'hA2, 1, 0, 0, 4'h0, "R10");
      op(9'h080, 8'hB1, 1, 0, 0, 4'h0, "R10");
      op(9'h0FF, 8'hB2, 1, 0, 0, 4'h0, "R10");
      op(9'h17F, 8'hC1, 1, 0, 0, 4'h0, "R10");
      op(9'h180, 8'hD1, 1, 0, 0, 4'h0, "R10");
      rd(9'h000, "R3"); chk(rdata == 8'hA1, "R3", rdata, 8'hA1);
      rd(9'h0FF, "R10"); chk(rdata == 8'hB2, "R10", rdata, 8'hB2);

      // R2: write and read same address same cycle returns old byte
      op(9'h000, 8'h5C, 1, 0, 0, 4'h0, "R2");
      chk(rdata == 8'hA1, "R2", rdata, 8'hA1);
      rd(9'h000, "R2"); chk(rdata == 8'h5C, "R2", rdata, 8'h5C);

      // R8: reserved window reads zero, write discarded
      op(9'd256, 8'hFF, 1, 0, 0, 4'h0, "R8");
      chk(wr_reject == 1'b0, "R8", wr_reject, 0);
      rd(9'd256, "R8"); chk(rdata == 8'h00, "R8", rdata, 0);
      op(9'd319, 8'h77, 1, 0, 0, 4'h0, "R8");
      rd(9'd319, "R8"); chk(rdata == 8'h00, "R8", rdata, 0);

      // R6/R7: lock all four, bit 3 stays zero
      op(9'd0, 8'h00, 0, 1, 0, 4'hF, "R6");
      chk(prot_state == 4'h7, "R7", prot_state, 7);

      // R4/R5: locked write dropped
      op(9'h000, 8'h99, 1, 0, 0, 4'h0, "R4");
      chk(wr_reject == 1'b1, "R5", wr_reject, 1);
      rd(9'h000, "R4"); chk(rdata == 8'h5C, "R4", rdata, 8'h5C);
      chk(wr_reject == 1'b0, "R5", wr_reject, 0);
      op(9'd300, 8'h11, 1, 0, 0, 4'h0, "R8");
      chk(wr_reject == 1'b1, "R8", wr_reject, 1);

      // R7: user block writable while locked
      op(9'd511, 8'h3E, 1, 0, 0, 4'h0, "R7");
      chk(wr_reject == 1'b0, "R7", wr_reject, 0);
      rd(9'd511, "R7"); chk(rdata == 8'h3E, "R7", rdata, 8'h3E);

      // R6: set and clear together, clear wins
      op(9'd0, 8'h00, 0, 1, 1, 4'h3, "R6");
      chk(prot_state == 4'h4, "R6", prot_state, 4);

      // R9: write coincident with lock set is judged on old state
      op(9'h010, 8'h42, 1, 1, 0, 4'h1, "R9");
      chk(wr_reject == 1'b0, "R9", wr_reject, 0);
      rd(9'h010, "R9"); chk(rdata == 8'h42, "R9", rdata, 8'h42);
      // R9: write coincident with release is still rejected
      op(9'h011, 8'h43, 1, 0, 1, 4'h1, "R9");
      chk(wr_reject == 1'b1, "R9", wr_reject, 1);
      rd(9'h011, "R9"); chk(rdata == 8'h00, "R9", rdata, 0);
      // R6: released block accepts writes again
      op(9'h011, 8'h44, 1, 0, 0, 4'h0, "R6");
      rd(9'h011, "R6"); chk(rdata == 8'h44, "R6", rdata, 8'h44);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [8:0] a;
         int unsigned pick;
         pick = $urandom_range(0, 9);
         case (pick)
            0: a = 9'd255 + 9'($urandom_range(0, 2));
            1: a = 9'd319 + 9'($urandom_range(0, 2));
            2: a = 9'd383 + 9'($urandom_range(0, 1));
            3: a = 9'd127 + 9'($urandom_range(0, 1));
            default: a = 9'($urandom_range(0, 511));
         endcase
         op(a, 8'($urandom), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
            4'($urandom), "R2");
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule